// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a peripheral has left stuck in the middle of a transfer. That happens, for example, when the controller side was reset and the peripheral was not. A single-cycle `start` pulse hands both open-drain lines to the block. It checks whether the bus is idle-high and then runs a fixed script of pseudo-stop conditions and SCL pulses. The script aborts a write the peripheral was still accepting. It also lets a read the peripheral was still driving run out, so that the read ends on a NAK.

Each step of the script lasts one half bit-time, which is 5 µs by default. The outputs `scl_pull` and `sda_pull` drive the pad low when high and release it when low. The line inputs pass through a synchronizer. The block samples them only at the end of a released phase, and it uses that sample to decide whether a pseudo-stop is safe. When the script ends, both lines are released and `done` pulses for one cycle.

Top module: `i2c_bus_rescue`

## Requirements
- R1: After reset, and whenever reset is asserted, `scl_pull`, `sda_pull`, `busy` and `done` are all 0.
- R2: Every step lasts HALF_CYC clock cycles, where HALF_CYC = (CLK_HZ/1000)*HALF_NS/1000000, with a minimum of 1. Every low pull on either line therefore lasts exactly HALF_CYC cycles.
- R3: A run starts with one released step. If both lines read high at the end of that step, the block issues a pseudo-stop: SDA pulled low for one step while SCL is released, then released for one step.
- R4: If either line reads low at the end of the first step, the block first gives one extra SCL pulse (low one step, released one step). It then issues a pseudo-stop only if both lines read high at the end of that pulse.
- R5: Next come exactly PULSES (default 9) SCL pulses, each low for one step and released for one step, whatever level SCL actually shows.
- R6: After the last pulse, a final pseudo-stop is issued only if both lines read high at the end of its released step.
- R7: `sda_pull` and `scl_pull` are never both 1 in the same cycle.
- R8: `done` is a one-cycle pulse, raised N*HALF_CYC cycles after the edge that accepted `start`, where N is the number of steps run. In the cycle of `done`, both pulls are 0 and `busy` is 0.
- R9: A `start` pulse that arrives while `busy` is 1 is ignored. The run keeps its length, and only one `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the recovery script |
| scl_in | input | 1 | Sensed SCL level (asynchronous) |
| sda_in | input | 1 | Sensed SDA level (asynchronous) |
| scl_pull | output | 1 | 1 drives SCL low, 0 releases it |
| sda_pull | output | 1 | 1 drives SDA low, 0 releases it |
| busy | output | 1 | A recovery run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The checker assumes that a released step is longer than the synchronizer depth, so that a line level settles before it is sampled. The bench keeps to this by using a five-cycle step with a two-stage synchronizer. Its peripheral model changes SDA only on a rising SCL edge at the start of a released step. The pulse-count and pulse-width checks also assume `start` is a single-cycle pulse. Every scenario drives `start` for exactly one cycle, including the extra pulse sent in the middle of a run.

// File: rtl/i2c_rescue_pkg.sv
package i2c_rescue_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_STOP_LO,
    ST_STOP_HI,
    ST_XCLK_LO,
    ST_XCLK_HI,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_END_LO,
    ST_END_HI
  } rescue_state_e;

  function automatic int half_cycles(input int clk_hz, input int half_ns);
    longint v;
    v = (longint'(clk_hz) / 1000) * longint'(half_ns) / 1000000;
    return (v < 1) ? 1 : int'(v);
  endfunction

endpackage

// File: rtl/i2c_rescue_sync.sv
module i2c_rescue_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= '1;
          else     pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '1;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_rescue_timer.sv
module i2c_rescue_timer #(
  parameter int HALF_CYC = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] count;

  assign tick = run && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) count <= '0;
    else                     count <= count + 1'b1;
  end
endmodule

// File: rtl/i2c_rescue_script.sv
module i2c_rescue_script
  import i2c_rescue_pkg::*;
#(
  parameter int PULSES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_pull,
  output logic sda_pull,
  output logic busy,
  output logic done
);
  localparam int PCW = $clog2(PULSES + 1);
  localparam logic [PCW-1:0] PLAST = PCW'(PULSES - 1);

  rescue_state_e state_q, state_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic           done_d;
  logic           lines_hi;

  assign lines_hi = scl_s && sda_s;

  always_comb begin
    state_d = state_q;
    pcnt_d  = pcnt_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE:    if (start) state_d = ST_SETTLE;
      ST_SETTLE:  if (tick) state_d = lines_hi ? ST_STOP_LO : ST_XCLK_LO;
      ST_XCLK_LO: if (tick) state_d = ST_XCLK_HI;
      ST_XCLK_HI: if (tick) begin
        state_d = lines_hi ? ST_STOP_LO : ST_CLK_LO;
        pcnt_d  = '0;
      end
      ST_STOP_LO: if (tick) state_d = ST_STOP_HI;
      ST_STOP_HI: if (tick) begin
        state_d = ST_CLK_LO;
        pcnt_d  = '0;
      end
      ST_CLK_LO:  if (tick) state_d = ST_CLK_HI;
      ST_CLK_HI:  if (tick) begin
        if (pcnt_q == PLAST) begin
          if (lines_hi) begin
            state_d = ST_END_LO;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end else begin
          pcnt_d  = pcnt_q + 1'b1;
          state_d = ST_CLK_LO;
        end
      end
      ST_END_LO:  if (tick) state_d = ST_END_HI;
      ST_END_HI:  if (tick) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      pcnt_q   <= '0;
      done     <= 1'b0;
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      state_q  <= state_d;
      pcnt_q   <= pcnt_d;
      done     <= done_d;
      scl_pull <= (state_d == ST_XCLK_LO) || (state_d == ST_CLK_LO);
      sda_pull <= (state_d == ST_STOP_LO) || (state_d == ST_END_LO);
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/i2c_bus_rescue.sv
module i2c_bus_rescue
  import i2c_rescue_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int HALF_NS     = 5000,
  parameter int SYNC_STAGES = 2,
  parameter int PULSES      = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_pull,
  output logic sda_pull,
  output logic busy,
  output logic done
);
  localparam int HALF_CYC = half_cycles(CLK_HZ, HALF_NS);

  logic [1:0] lines_s;
  logic       tick;

  i2c_rescue_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (lines_s)
  );

  i2c_rescue_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .tick (tick)
  );

  i2c_rescue_script #(.PULSES(PULSES)) u_script (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .tick     (tick),
    .scl_s    (lines_s[1]),
    .sda_s    (lines_s[0]),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .busy     (busy),
    .done     (done)
  );
endmodule

// File: rtl/i2c_bus_rescue_chk.sv
module i2c_bus_rescue_chk #(
  parameter int HALF_CYC = 500,
  parameter int PULSES   = 9
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic scl_pull,
  input logic sda_pull,
  input logic busy,
  input logic done
);
  logic [31:0] scl_len;
  logic [31:0] sda_len;
  logic [7:0]  scl_pulses;
  logic        scl_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_len    <= '0;
      sda_len    <= '0;
      scl_pulses <= '0;
      scl_prev   <= 1'b0;
    end else begin
      scl_len  <= scl_pull ? scl_len + 1 : '0;
      sda_len  <= sda_pull ? sda_len + 1 : '0;
      scl_prev <= scl_pull;
      if (done)                       scl_pulses <= '0;
      else if (scl_pull && !scl_prev) scl_pulses <= scl_pulses + 1'b1;
    end
  end

  // R7
  no_dual_pull_chk: assert property (@(posedge clk) disable iff (rst)
    !(scl_pull && sda_pull));

  // R2
  scl_width_chk: assert property (@(posedge clk) disable iff (rst)
    (!scl_pull && scl_len != 0) |-> (scl_len == HALF_CYC));

  // R2
  sda_width_chk: assert property (@(posedge clk) disable iff (rst)
    (!sda_pull && sda_len != 0) |-> (sda_len == HALF_CYC));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_released_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!scl_pull && !sda_pull && !busy));

  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_pull && !sda_pull));

  // R5
  pulse_count_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (scl_pulses == PULSES || scl_pulses == PULSES + 1));

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> busy);
endmodule

bind i2c_bus_rescue i2c_bus_rescue_chk #(
  .HALF_CYC (HALF_CYC),
  .PULSES   (PULSES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .scl_pull (scl_pull),
  .sda_pull (sda_pull),
  .busy     (busy),
  .done     (done)
);

// File: tb/i2c_bus_rescue_bench.sv
`timescale 1ns/1ps
module i2c_bus_rescue_bench;
  localparam int CLK_HZ  = 1_000_000;
  localparam int HALF_NS = 5000;
  localparam int H       = (CLK_HZ / 1000) * HALF_NS / 1000000;  // R2 formula, = 5

  // {scl_stuck, sda_hold_rises, exp_scl_pulses, exp_sda_pulses, exp_steps}
  localparam logic [24:0] VEC [5] = '{
    {1'b0, 8'd0,   4'd9,  4'd2, 8'd23},
    {1'b0, 8'd1,   4'd10, 4'd2, 8'd25},
    {1'b0, 8'd3,   4'd10, 4'd1, 8'd23},
    {1'b0, 8'd255, 4'd10, 4'd0, 8'd21},
    {1'b1, 8'd0,   4'd10, 4'd0, 8'd21}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic scl_pull, sda_pull, busy, done;

  logic       scl_stuck = 1'b0;
  logic [7:0] hold = 8'd0;
  logic [7:0] rises = 8'd0;
  logic       lprev = 1'b1;
  logic       model_clr = 1'b0;
  logic       scl_line, sda_line;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  logic mon_clr = 1'b0;
  int   scl_p, sda_p, scl_lo, sda_lo, done_n, done_cyc;
  logic mscl_prev, msda_prev;

  assign scl_line = !scl_pull && !scl_stuck;
  assign sda_line = !sda_pull && !(rises < hold);

  i2c_bus_rescue #(
    .CLK_HZ(CLK_HZ), .HALF_NS(HALF_NS), .SYNC_STAGES(2), .PULSES(9)
  ) u_i2c_bus_rescue (
    .clk(clk), .rst(rst), .start(start),
    .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull),
    .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // peripheral: holds SDA low until it has seen `hold` SCL rising edges
  always @(posedge clk) begin
    if (model_clr) begin
      rises <= 8'd0;
      lprev <= 1'b1;
    end else begin
      if (scl_line && !lprev) rises <= rises + 8'd1;
      lprev <= scl_line;
    end
  end

  always @(negedge clk) begin
    if (mon_clr) begin
      scl_p = 0; sda_p = 0; scl_lo = 0; sda_lo = 0;
      done_n = 0; done_cyc = 0;
      mscl_prev = 1'b0; msda_prev = 1'b0;
    end else begin
      if (scl_pull && !mscl_prev) scl_p++;
      if (sda_pull && !msda_prev) sda_p++;
      if (scl_pull) scl_lo++;
      if (sda_pull) sda_lo++;
      if (done) begin done_n++; done_cyc = cyc; end
      mscl_prev = scl_pull;
      msda_prev = sda_pull;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input logic stuck, input logic [7:0] hd,
                          input bit restart, output int steps_cyc);
    int c0;
    @(negedge clk);
    scl_stuck = stuck; hold = hd; model_clr = 1'b1; mon_clr = 1'b1;
    @(negedge clk);
    model_clr = 1'b0; mon_clr = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c0 = cyc;
    for (int i = 0; i < 2000 && done_n == 0; i++) begin
      @(negedge clk);
      if (restart && i == 20) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    if (done_n == 0) chk("R8 watchdog: done never seen", 0, 1);
    steps_cyc = done_cyc - c0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int len;
    repeat (4) @(negedge clk);
    chk("R1 scl_pull in reset", int'(scl_pull), 0);
    chk("R1 sda_pull in reset", int'(sda_pull), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);

    for (int v = 0; v < 5; v++) begin
      run_case(VEC[v][24], VEC[v][23:16], 1'b0, len);
      chk($sformatf("R4 R5 scl pulses vec%0d", v), scl_p, int'(VEC[v][15:12]));
      chk($sformatf("R3 R6 sda pulses vec%0d", v), sda_p, int'(VEC[v][11:8]));
      chk($sformatf("R2 scl low cycles vec%0d", v), scl_lo, int'(VEC[v][15:12]) * H);
      chk($sformatf("R2 sda low cycles vec%0d", v), sda_lo, int'(VEC[v][11:8]) * H);
      chk($sformatf("R8 run length vec%0d", v), len, int'(VEC[v][7:0]) * H);
      chk($sformatf("R8 done count vec%0d", v), done_n, 1);
      chk($sformatf("R8 released after vec%0d", v), int'(scl_pull | sda_pull | busy), 0);
    end

    // R9: second start in the middle of a run is ignored
    run_case(1'b0, 8'd0, 1'b1, len);
    chk("R9 run length with extra start", len, 23 * H);
    chk("R9 single done", done_n, 1);
    chk("R9 not busy after done", int'(busy), 0);

    // R1: reset in the middle of a run releases everything
    @(negedge clk);
    scl_stuck = 1'b0; hold = 8'd255;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3 * H + 2) @(negedge clk);
    chk("R1 mid-run pull active before reset", int'(scl_pull), 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset scl_pull", int'(scl_pull), 0);
    chk("R1 mid-run reset busy", int'(busy), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule